// File: doc/BRIEF.md
# Selection and DMA Transfer Sequencer

This block runs the initiator side of a parallel-bus storage controller after the host writes a command code. It resolves a target from a 3-bit bus ID and a presence vector. It reports the outcome of a selection through three values: a status byte, an interrupt-cause byte and a sequence-step value. For a transfer, it works out how many bytes to move, then hands the DMA engine one chunk at a time. Each chunk is never larger than what the attached device currently offers.

The host writes a command byte. Bit 7 of that byte asks for DMA, and bits 6:0 pick the operation:

| Code | Operation |
|------|-----------|
| 0x42 | Select with attention |
| 0x43 | Select with attention and stop |
| 0x10 | Transfer information |
| 0x11 | Initiator command complete |
| 0x12 | Message accepted |

The device model reports its data length and direction, data availability and completion. Command execution and memory traffic live outside the block.

The sequencer has four states:

| State | Meaning |
|-------|---------|
| S_IDLE | No DMA in flight |
| S_WAIT | A transfer length is armed; waiting for device data |
| S_XFER | A data chunk is outstanding |
| S_CMDF | Command bytes are being fetched by DMA |

Its transitions are:

| Transition | Taken when |
|------------|------------|
| IDLE→WAIT | Transfer with DMA and a non-zero effective length |
| IDLE→CMDF | Transfer with DMA while in command-capture mode |
| WAIT→XFER | Device data becomes ready |
| XFER→WAIT | A chunk is acknowledged and bytes remain |
| XFER→IDLE | The last chunk is acknowledged |
| CMDF→IDLE | The command-byte chunk is acknowledged |
| WAIT→IDLE | Device done |
| any→IDLE | A new selection, which cancels whatever is in progress |

Top module: `sds_seq_top`

## Requirements
- R1: After reset: status 0, interrupt cause 0, sequence step 0, flags 0, irq low, no chunk request, command-capture mode off. Whenever irq is high, the interrupt cause is non-zero.
- R2: A selection (0x42 or 0x43) whose target, `tgt_present_i[busid_i]`, is clear gives status 0, interrupt cause 0x20, step 0 and raises irq.
- R3: A successful 0x42 gives interrupt cause 0x18 and step 4. Status is 0x11 for data-in, 0x10 for data-out, and 0x00 for a device length of zero.
- R4: A successful 0x43 turns command-capture mode on and gives status 0x12, interrupt cause 0x18, step 4 and irq.
- R5: For a transfer, the count is `cnt_i` (low byte in 7:0, middle byte in 15:8), and a count of 0 means 65536. The effective length is min(count, 32) in command-capture mode and min(count, remaining device bytes) otherwise. An effective length of 0 completes at once.
- R6: Starting a data transfer clears status bit 4. Each chunk is min(remaining, device bytes available), and each acknowledge lowers the remaining length by that chunk.
- R7: DMA completion sets status bit 4, interrupt cause 0x10, step 0 and flags 0, pulses `cnt_clr_o` for one cycle, and raises irq.
- R8: Device done while a target is active gives status 0x13, interrupt cause 0x10, step 0, and releases the target.
- R9: 0x91 gives status 0x17, interrupt cause 0x08 and step 4. 0x11 without DMA ORs 7 into status, sets interrupt cause 0x08 and sets flags to 2.
- R10: 0x92 gives status 0x13, interrupt cause 0x20 and step 0. 0x12 without DMA sets flags to 2 and leaves status alone.
- R11: While device data is not ready, no chunk is requested and the remaining length is held, with no time limit.
- R12: A new selection drops any outstanding chunk request and clears the pending and remaining lengths.
- R13: An interrupt acknowledge clears the interrupt cause, clears status bit 4, sets step 4 and lowers irq.
- R14: In command-capture mode, a transfer with DMA requests one chunk of the effective length. Its acknowledge, or a transfer without DMA, executes the command: status follows R3, interrupt cause is 0x18, step is 4, and command-capture mode turns off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 8 | Command code; bit 7 = DMA |
| busid_i | input | ID_W | Target ID (bus ID bits 2:0) |
| tgt_present_i | input | NUM_TGT | One bit per present target |
| cnt_i | input | CNT_W | Programmed transfer count |
| dev_len_i | input | LEN_W | Device data length for the command |
| dev_dir_in_i | input | 1 | 1 = device sends data to host |
| dev_rdy_i | input | 1 | Device data available |
| dev_avail_i | input | LEN_W | Bytes the device currently offers |
| dev_done_i | input | 1 | Device command complete |
| chunk_ack_i | input | 1 | DMA chunk finished |
| irq_ack_i | input | 1 | Host read of the interrupt cause |
| chunk_req_o | output | 1 | Chunk request to the DMA engine |
| chunk_len_o | output | LEN_W | Chunk length |
| status_o | output | 7 | Status byte, bits 6:0 |
| intr_o | output | 8 | Interrupt cause |
| seq_o | output | 3 | Sequence step |
| flags_o | output | 5 | FIFO flags |
| cnt_clr_o | output | 1 | Pulse: clear count low and middle |
| irq_o | output | 1 | Interrupt request |
| cmd_mode_o | output | 1 | Command-capture mode |

## Verification
The bench goes after the ends of the length clipping:

- A zero count must become 65536, not 0. A design that treated it as 0 would finish at once and never request a chunk.
- The 32-byte command cap must win over a large count. Without it, a command fetch would ask for 65536 bytes.
- A transfer to a device with no bytes left must complete at once rather than sit in S_WAIT.

It also covers the remaining corner cases:

- It holds device data back for several cycles. A design with a hidden timeout, or one that requests without data, would raise a chunk request.
- It fires a selection at an absent target in the middle of a transfer. A design that forgot to cancel would keep the chunk request up.
- It checks each completion path's distinct status and cause codes.
- It checks bits 7:0 of the count against bits 15:8, so a byte swap shows up as a wrong chunk length.

// File: rtl/sds_pkg.sv
package sds_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_XFER,
        S_CMDF
    } seq_state_e;

    localparam logic [6:0] OP_XFER   = 7'h10;
    localparam logic [6:0] OP_ICC    = 7'h11;
    localparam logic [6:0] OP_MSGOK  = 7'h12;
    localparam logic [6:0] OP_SELA   = 7'h42;
    localparam logic [6:0] OP_SELAS  = 7'h43;

    localparam logic [6:0] ST_TC     = 7'h10;
    localparam logic [6:0] PH_DOUT   = 7'h00;
    localparam logic [6:0] PH_DIN    = 7'h01;
    localparam logic [6:0] PH_CMD    = 7'h02;
    localparam logic [6:0] PH_STAT   = 7'h03;
    localparam logic [6:0] PH_MIN    = 7'h07;

    localparam logic [7:0] IC_FUNC   = 8'h08;
    localparam logic [7:0] IC_BUS    = 8'h10;
    localparam logic [7:0] IC_DISC   = 8'h20;
    localparam logic [7:0] IC_SELOK  = 8'h18;

    localparam logic [2:0] SQ_ZERO   = 3'd0;
    localparam logic [2:0] SQ_CMD    = 3'd4;

endpackage

// File: rtl/sds_tgt_check.sv
module sds_tgt_check #(
    parameter int NUM_TGT = 8,
    localparam int ID_W   = $clog2(NUM_TGT)
) (
    input  logic [ID_W-1:0]    id_i,
    input  logic [NUM_TGT-1:0] present_i,
    output logic               hit_o
);
    always_comb begin
        hit_o = 1'b0;
        for (int t = 0; t < NUM_TGT; t++) begin
            if (id_i == ID_W'(t)) begin
                hit_o = present_i[t];
            end
        end
    end
endmodule

// File: rtl/sds_len_calc.sv
module sds_len_calc #(
    parameter int CNT_W   = 16,
    parameter int CMD_MAX = 32,
    localparam int LEN_W  = CNT_W + 1
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cmd_mode_i,
    input  logic [LEN_W-1:0] dev_rem_i,
    output logic [LEN_W-1:0] eff_o
);
    localparam logic [LEN_W-1:0] FULL_CNT = LEN_W'(1) << CNT_W;
    localparam logic [LEN_W-1:0] CMD_CAP  = LEN_W'(CMD_MAX);

    logic [LEN_W-1:0] prog_len;
    logic [LEN_W-1:0] limit;

    always_comb begin
        prog_len = (cnt_i == '0) ? FULL_CNT : {1'b0, cnt_i};
        limit    = cmd_mode_i ? CMD_CAP : dev_rem_i;
        eff_o    = (prog_len < limit) ? prog_len : limit;
    end
endmodule

// File: rtl/sds_seq_top.sv
module sds_seq_top
    import sds_pkg::*;
#(
    parameter int NUM_TGT = 8,
    parameter int CNT_W   = 16,
    parameter int CMD_MAX = 32,
    localparam int ID_W   = $clog2(NUM_TGT),
    localparam int LEN_W  = CNT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid_i,
    input  logic [7:0]         cmd_code_i,
    input  logic [ID_W-1:0]    busid_i,
    input  logic [NUM_TGT-1:0] tgt_present_i,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic [LEN_W-1:0]   dev_len_i,
    input  logic               dev_dir_in_i,
    input  logic               dev_rdy_i,
    input  logic [LEN_W-1:0]   dev_avail_i,
    input  logic               dev_done_i,
    input  logic               chunk_ack_i,
    input  logic               irq_ack_i,
    output logic               chunk_req_o,
    output logic [LEN_W-1:0]   chunk_len_o,
    output logic [6:0]         status_o,
    output logic [7:0]         intr_o,
    output logic [2:0]         seq_o,
    output logic [4:0]         flags_o,
    output logic               cnt_clr_o,
    output logic               irq_o,
    output logic               cmd_mode_o
);

    seq_state_e       state_q, state_d;
    logic [6:0]       status_q, status_d;
    logic [7:0]       intr_q, intr_d;
    logic [2:0]       seq_q, seq_d;
    logic [4:0]       flags_q, flags_d;
    logic             irq_q, irq_d;
    logic             cmd_mode_q, cmd_mode_d;
    logic             active_q, active_d;
    logic [LEN_W-1:0] dev_rem_q, dev_rem_d;
    logic [LEN_W-1:0] rem_q, rem_d;
    logic [LEN_W-1:0] chunk_q, chunk_d;
    logic             cnt_clr_q, cnt_clr_d;

    logic             tgt_hit;
    logic [LEN_W-1:0] eff_len;
    logic             is_dma;
    logic [6:0]       op;
    logic             is_sel;
    logic             do_done;
    logic             do_exec;
    logic [LEN_W-1:0] rem_after;
    logic [LEN_W-1:0] avail_cut;

    assign is_dma = cmd_code_i[7];
    assign op     = cmd_code_i[6:0];
    assign is_sel = (op == OP_SELA) || (op == OP_SELAS);

    sds_tgt_check #(.NUM_TGT(NUM_TGT)) u_tgt (
        .id_i      (busid_i),
        .present_i (tgt_present_i),
        .hit_o     (tgt_hit)
    );

    sds_len_calc #(.CNT_W(CNT_W), .CMD_MAX(CMD_MAX)) u_len (
        .cnt_i      (cnt_i),
        .cmd_mode_i (cmd_mode_q),
        .dev_rem_i  (dev_rem_q),
        .eff_o      (eff_len)
    );

    assign rem_after = rem_q - chunk_q;
    assign avail_cut = (dev_avail_i < rem_q) ? dev_avail_i : rem_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and register-file updates
    always_comb begin
        state_d    = state_q;
        status_d   = status_q;
        intr_d     = intr_q;
        seq_d      = seq_q;
        flags_d    = flags_q;
        irq_d      = irq_q;
        cmd_mode_d = cmd_mode_q;
        active_d   = active_q;
        dev_rem_d  = dev_rem_q;
        rem_d      = rem_q;
        chunk_d    = chunk_q;
        cnt_clr_d  = 1'b0;
        do_done    = 1'b0;
        do_exec    = 1'b0;

        if (irq_ack_i) begin
            intr_d   = 8'h00;
            status_d = status_q & ~ST_TC;
            seq_d    = SQ_CMD;
            irq_d    = 1'b0;
        end

        if (cmd_valid_i) begin
            unique case (op)
                OP_SELA, OP_SELAS: begin
                    state_d    = S_IDLE;
                    rem_d      = '0;
                    chunk_d    = '0;
                    cmd_mode_d = 1'b0;
                    active_d   = 1'b0;
                    dev_rem_d  = '0;
                    if (!tgt_hit) begin
                        status_d = 7'h00;
                        intr_d   = IC_DISC;
                        seq_d    = SQ_ZERO;
                        irq_d    = 1'b1;
                    end else begin
                        active_d = 1'b1;
                        if (op == OP_SELA) begin
                            do_exec = 1'b1;
                        end else begin
                            cmd_mode_d = 1'b1;
                            status_d   = ST_TC | PH_CMD;
                            intr_d     = IC_SELOK;
                            seq_d      = SQ_CMD;
                            irq_d      = 1'b1;
                        end
                    end
                end
                OP_XFER: begin
                    if (cmd_mode_q) begin
                        if (is_dma) begin
                            chunk_d = eff_len;
                            state_d = S_CMDF;
                        end else begin
                            cmd_mode_d = 1'b0;
                            do_exec    = 1'b1;
                        end
                    end else if (is_dma) begin
                        status_d = status_d & ~ST_TC;
                        if (eff_len == '0) begin
                            do_done = 1'b1;
                        end else begin
                            rem_d   = eff_len;
                            state_d = S_WAIT;
                        end
                    end
                end
                OP_ICC: begin
                    if (is_dma) begin
                        status_d = ST_TC | PH_MIN;
                        seq_d    = SQ_CMD;
                    end else begin
                        status_d = status_d | PH_MIN;
                        flags_d  = 5'd2;
                    end
                    intr_d = IC_FUNC;
                    irq_d  = 1'b1;
                end
                OP_MSGOK: begin
                    if (is_dma) begin
                        status_d = ST_TC | PH_STAT;
                    end else begin
                        flags_d = 5'd2;
                    end
                    intr_d = IC_DISC;
                    seq_d  = SQ_ZERO;
                    irq_d  = 1'b1;
                end
                default: ;
            endcase
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (dev_done_i && active_q) begin
                        status_d  = PH_STAT;
                        active_d  = 1'b0;
                        dev_rem_d = '0;
                        do_done   = 1'b1;
                    end
                end
                S_WAIT: begin
                    if (dev_done_i) begin
                        status_d  = PH_STAT;
                        active_d  = 1'b0;
                        dev_rem_d = '0;
                        do_done   = 1'b1;
                    end else if (dev_rdy_i && dev_avail_i != '0) begin
                        chunk_d = avail_cut;
                        state_d = S_XFER;
                    end
                end
                S_XFER: begin
                    if (chunk_ack_i) begin
                        rem_d     = rem_after;
                        dev_rem_d = (chunk_q > dev_rem_q) ? '0 : dev_rem_q - chunk_q;
                        if (rem_after == '0) begin
                            do_done = 1'b1;
                        end else begin
                            state_d = S_WAIT;
                        end
                    end
                end
                S_CMDF: begin
                    if (chunk_ack_i) begin
                        cmd_mode_d = 1'b0;
                        chunk_d    = '0;
                        state_d    = S_IDLE;
                        do_exec    = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (do_exec) begin
            dev_rem_d = dev_len_i;
            if (dev_len_i != '0) begin
                status_d = ST_TC | (dev_dir_in_i ? PH_DIN : PH_DOUT);
            end else begin
                status_d = 7'h00;
            end
            intr_d = IC_SELOK;
            seq_d  = SQ_CMD;
            irq_d  = 1'b1;
        end

        if (do_done) begin
            status_d  = status_d | ST_TC;
            intr_d    = IC_BUS;
            seq_d     = SQ_ZERO;
            flags_d   = 5'd0;
            cnt_clr_d = 1'b1;
            irq_d     = 1'b1;
            rem_d     = '0;
            state_d   = S_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q   <= '0;
            intr_q     <= '0;
            seq_q      <= '0;
            flags_q    <= '0;
            irq_q      <= 1'b0;
            cmd_mode_q <= 1'b0;
            active_q   <= 1'b0;
            dev_rem_q  <= '0;
            rem_q      <= '0;
            chunk_q    <= '0;
            cnt_clr_q  <= 1'b0;
        end else begin
            status_q   <= status_d;
            intr_q     <= intr_d;
            seq_q      <= seq_d;
            flags_q    <= flags_d;
            irq_q      <= irq_d;
            cmd_mode_q <= cmd_mode_d;
            active_q   <= active_d;
            dev_rem_q  <= dev_rem_d;
            rem_q      <= rem_d;
            chunk_q    <= chunk_d;
            cnt_clr_q  <= cnt_clr_d;
        end
    end

    // Outputs
    always_comb begin
        chunk_req_o = (state_q == S_XFER) || (state_q == S_CMDF);
        chunk_len_o = chunk_q;
        status_o    = status_q;
        intr_o      = intr_q;
        seq_o       = seq_q;
        flags_o     = flags_q;
        cnt_clr_o   = cnt_clr_q;
        irq_o       = irq_q;
        cmd_mode_o  = cmd_mode_q;
    end

    // R1: an asserted interrupt always carries a cause
    a_r1_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (intr_o != 8'h00));

    // R2: absent target gives the disconnect codes
    a_r2_absent_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && is_sel && !tgt_hit) |=>
        (intr_o == IC_DISC && status_o == 7'h00 && seq_o == SQ_ZERO && irq_o));

    // R6: a data chunk is never empty and never exceeds the remaining length
    a_r6_chunk_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_XFER) |-> (chunk_q != '0 && chunk_q <= rem_q));

    // R6: each acknowledge takes exactly one chunk off the remaining length
    a_r6_rem_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_XFER && chunk_ack_i && !cmd_valid_i) |=>
        (rem_q == $past(rem_q) - $past(chunk_q)));

    // R7: completion pulse comes with the completion codes
    a_r7_done_codes: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr_o |-> (intr_o == IC_BUS && seq_o == SQ_ZERO && irq_o && status_o[4]));

    // R11: waiting for data holds the remaining length
    a_r11_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && !dev_rdy_i && !cmd_valid_i && !dev_done_i) |=>
        (state_q == S_WAIT && $stable(rem_q)));

    // R12: a selection cancels any outstanding chunk
    a_r12_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && is_sel) |=> !chunk_req_o);

    // R14: a command-byte fetch is bounded by the command cap
    a_r14_cmd_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CMDF) |-> (chunk_q != '0 && chunk_q <= LEN_W'(CMD_MAX)));

endmodule

// File: tb/sds_seq_top_tb_top.sv
`timescale 1ns/100ps
module sds_seq_top_tb_top;

    localparam int NUM_TGT = 8;
    localparam int CNT_W   = 16;
    localparam int ID_W    = 3;
    localparam int LEN_W   = 17;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cmd_valid_i = 1'b0;
    logic [7:0]         cmd_code_i = '0;
    logic [ID_W-1:0]    busid_i = '0;
    logic [NUM_TGT-1:0] tgt_present_i = '0;
    logic [CNT_W-1:0]   cnt_i = '0;
    logic [LEN_W-1:0]   dev_len_i = '0;
    logic               dev_dir_in_i = 1'b0;
    logic               dev_rdy_i = 1'b0;
    logic [LEN_W-1:0]   dev_avail_i = '0;
    logic               dev_done_i = 1'b0;
    logic               chunk_ack_i = 1'b0;
    logic               irq_ack_i = 1'b0;
    logic               chunk_req_o;
    logic [LEN_W-1:0]   chunk_len_o;
    logic [6:0]         status_o;
    logic [7:0]         intr_o;
    logic [2:0]         seq_o;
    logic [4:0]         flags_o;
    logic               cnt_clr_o;
    logic               irq_o;
    logic               cmd_mode_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sds_seq_top #(.NUM_TGT(NUM_TGT), .CNT_W(CNT_W), .CMD_MAX(32)) dut_i (
        .clk, .rst_n, .cmd_valid_i, .cmd_code_i, .busid_i, .tgt_present_i,
        .cnt_i, .dev_len_i, .dev_dir_in_i, .dev_rdy_i, .dev_avail_i,
        .dev_done_i, .chunk_ack_i, .irq_ack_i, .chunk_req_o, .chunk_len_o,
        .status_o, .intr_o, .seq_o, .flags_o, .cnt_clr_o, .irq_o, .cmd_mode_o
    );

    typedef struct packed {
        logic [7:0]  pres;
        logic [2:0]  id;
        logic [7:0]  cmd;
        logic [16:0] len;
        logic        din;
        logic [6:0]  st;
        logic [7:0]  ic;
        logic [2:0]  sq;
        logic        cm;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'hFF, 3'd3, 8'h42, 17'd100, 1'b1, 7'h11, 8'h18, 3'd4, 1'b0},
        '{8'hFF, 3'd2, 8'h42, 17'd9,   1'b0, 7'h10, 8'h18, 3'd4, 1'b0},
        '{8'hF7, 3'd3, 8'h42, 17'd9,   1'b1, 7'h00, 8'h20, 3'd0, 1'b0},
        '{8'h01, 3'd0, 8'h42, 17'd0,   1'b1, 7'h00, 8'h18, 3'd4, 1'b0},
        '{8'hFF, 3'd5, 8'h43, 17'd20,  1'b0, 7'h12, 8'h18, 3'd4, 1'b1},
        '{8'h20, 3'd5, 8'hC2, 17'd3,   1'b1, 7'h11, 8'h18, 3'd4, 1'b0},
        '{8'h00, 3'd0, 8'h43, 17'd4,   1'b0, 7'h00, 8'h20, 3'd0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] code);
        @(negedge clk);
        cmd_code_i  = code;
        cmd_valid_i = 1'b1;
        @(negedge clk);
        cmd_valid_i = 1'b0;
    endtask

    task automatic ack_irq();
        @(negedge clk);
        irq_ack_i = 1'b1;
        @(negedge clk);
        irq_ack_i = 1'b0;
    endtask

    task automatic ack_chunk();
        chunk_ack_i = 1'b1;
        @(negedge clk);
        chunk_ack_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", 32'(status_o), 32'h0);
        chk("R1 intr", 32'(intr_o), 32'h0);
        chk("R1 irq", 32'(irq_o), 32'h0);
        chk("R1 req", 32'(chunk_req_o), 32'h0);
        chk("R1 mode", 32'(cmd_mode_o), 32'h0);

        // Selection table: R2 R3 R4
        for (int v = 0; v < NV; v++) begin
            tgt_present_i = VECS[v].pres;
            busid_i       = VECS[v].id;
            dev_len_i     = VECS[v].len;
            dev_dir_in_i  = VECS[v].din;
            issue(VECS[v].cmd);
            chk("R2/R3/R4 status", 32'(status_o), 32'(VECS[v].st));
            chk("R2/R3/R4 intr", 32'(intr_o), 32'(VECS[v].ic));
            chk("R2/R3/R4 seq", 32'(seq_o), 32'(VECS[v].sq));
            chk("R4 mode", 32'(cmd_mode_o), 32'(VECS[v].cm));
            chk("R2/R3 irq", 32'(irq_o), 32'h1);
            ack_irq();
        end

        // Data-in transfer, chunked
        tgt_present_i = 8'hFF; busid_i = 3'd3; dev_len_i = 17'd100; dev_dir_in_i = 1'b1;
        issue(8'h42);
        ack_irq();
        chk("R13 status", 32'(status_o), 32'h01);
        chk("R13 intr", 32'(intr_o), 32'h0);
        chk("R13 seq", 32'(seq_o), 32'd4);
        chk("R13 irq", 32'(irq_o), 32'h0);
        cnt_i = 16'd40; dev_rdy_i = 1'b0; dev_avail_i = 17'd16;
        issue(8'h90);
        repeat (5) @(negedge clk);
        chk("R11 no request while waiting", 32'(chunk_req_o), 32'h0);
        dev_rdy_i = 1'b1;
        @(negedge clk);
        chk("R6 req", 32'(chunk_req_o), 32'h1);
        chk("R6 first chunk", 32'(chunk_len_o), 32'd16);
        ack_chunk();
        @(negedge clk);
        chk("R6 second chunk", 32'(chunk_len_o), 32'd16);
        ack_chunk();
        @(negedge clk);
        chk("R6 last chunk clipped", 32'(chunk_len_o), 32'd8);
        ack_chunk();
        chk("R7 status", 32'(status_o), 32'h11);
        chk("R7 intr", 32'(intr_o), 32'h10);
        chk("R7 seq", 32'(seq_o), 32'd0);
        chk("R7 cnt_clr", 32'(cnt_clr_o), 32'h1);
        chk("R7 flags", 32'(flags_o), 32'h0);
        chk("R7 req dropped", 32'(chunk_req_o), 32'h0);
        ack_irq();

        // R5 zero count clipped to remaining device bytes (100-40=60)
        cnt_i = 16'd0; dev_avail_i = 17'd200;
        issue(8'h90);
        @(negedge clk);
        chk("R5 zero count clip", 32'(chunk_len_o), 32'd60);
        ack_chunk();
        chk("R7 cnt_clr 2", 32'(cnt_clr_o), 32'h1);
        ack_irq();
        dev_rdy_i = 1'b0;

        // R8 device done
        @(negedge clk);
        dev_done_i = 1'b1;
        @(negedge clk);
        dev_done_i = 1'b0;
        chk("R8 status", 32'(status_o), 32'h13);
        chk("R8 intr", 32'(intr_o), 32'h10);
        chk("R8 seq", 32'(seq_o), 32'd0);
        ack_irq();

        // R5 effective length zero completes at once
        issue(8'h90);
        chk("R5 empty completes", 32'(intr_o), 32'h10);
        chk("R5 empty cnt_clr", 32'(cnt_clr_o), 32'h1);
        chk("R5 empty no req", 32'(chunk_req_o), 32'h0);
        ack_irq();

        // R9 / R10 completion commands
        issue(8'h91);
        chk("R9 dma status", 32'(status_o), 32'h17);
        chk("R9 dma intr", 32'(intr_o), 32'h08);
        chk("R9 dma seq", 32'(seq_o), 32'd4);
        ack_irq();
        issue(8'h92);
        chk("R10 dma status", 32'(status_o), 32'h13);
        chk("R10 intr", 32'(intr_o), 32'h20);
        chk("R10 seq", 32'(seq_o), 32'd0);
        ack_irq();
        issue(8'h11);
        chk("R9 pio status", 32'(status_o), 32'h07);
        chk("R9 pio intr", 32'(intr_o), 32'h08);
        chk("R9 pio flags", 32'(flags_o), 32'd2);
        ack_irq();

        // R5 byte order of count, then R12 cancel mid-transfer
        dev_len_i = 17'd70000; dev_dir_in_i = 1'b0;
        issue(8'h42);
        ack_irq();
        cnt_i = 16'h1234; dev_avail_i = 17'h1FFFF; dev_rdy_i = 1'b1;
        issue(8'h90);
        @(negedge clk);
        chk("R5 count bytes", 32'(chunk_len_o), 32'h1234);
        busid_i = 3'd6; tgt_present_i = 8'h0F;
        issue(8'h42);
        chk("R12 req dropped", 32'(chunk_req_o), 32'h0);
        chk("R12 intr", 32'(intr_o), 32'h20);
        repeat (3) @(negedge clk);
        chk("R12 stays cancelled", 32'(chunk_req_o), 32'h0);
        ack_irq();
        tgt_present_i = 8'hFF;
        issue(8'h42);
        ack_irq();
        cnt_i = 16'h0000;
        issue(8'h90);
        @(negedge clk);
        chk("R5 zero count is 65536", 32'(chunk_len_o), 32'h10000);
        ack_chunk();
        ack_irq();
        dev_rdy_i = 1'b0;

        // R14 command-capture mode
        busid_i = 3'd5; dev_len_i = 17'd20; dev_dir_in_i = 1'b0;
        issue(8'h43);
        ack_irq();
        cnt_i = 16'h0000;
        issue(8'h90);
        chk("R14 cmd fetch req", 32'(chunk_req_o), 32'h1);
        chk("R14 cmd cap 32", 32'(chunk_len_o), 32'd32);
        ack_chunk();
        chk("R14 exec status", 32'(status_o), 32'h10);
        chk("R14 exec intr", 32'(intr_o), 32'h18);
        chk("R14 exec seq", 32'(seq_o), 32'd4);
        chk("R14 mode off", 32'(cmd_mode_o), 32'h0);
        ack_irq();
        issue(8'h43);
        ack_irq();
        cnt_i = 16'd5;
        issue(8'h90);
        chk("R14 short fetch", 32'(chunk_len_o), 32'd5);
        issue(8'h43);
        ack_irq();
        dev_dir_in_i = 1'b1;
        issue(8'h10);
        chk("R14 pio exec status", 32'(status_o), 32'h11);
        chk("R14 pio exec intr", 32'(intr_o), 32'h18);
        chk("R14 pio mode off", 32'(cmd_mode_o), 32'h0);
        chk("R14 pio no req", 32'(chunk_req_o), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule